// File: doc/BRIEF.md
# Supervisor Mode Entry and Return Controller

This block decides when a small 16-bit processor leaves user mode for its single supervisor mode and when it goes back. Two causes can start the switch: a software trap instruction and a level-sensitive interrupt line from the peripherals. Both causes send the program counter to one fixed handler address. Both save the interrupted program counter in one shared user-PC register. While the core is in supervisor mode, no further entry is accepted. A return request reloads the program counter from the saved value and drops back to user mode.

The rest of the core drives `instrDone` once per finished instruction. Trap, interrupt and return requests count only in a cycle where that strobe is high. The controller answers in the same cycle with a PC-load strobe and the value to load, and the core takes that value at the next clock edge. Software in supervisor mode can read the saved user PC through `upcRead`. It can overwrite the saved user PC through `setUpcEn`/`setUpcVal` before returning, so the return can go to a different place.

Top module: `supv_trap_ctrl`

## Requirements
- R1: After reset the block is in user mode (`superMode`=0), the saved user PC reads 0x0000 and `pcLoad` is 0.
- R2: In user mode, a cycle with `instrDone`=1 and `swTrap`=1 drives `pcLoad`=1 with `pcLoadVal`=0x0002 in that cycle. From the next cycle, `superMode`=1 and `upcRead` equals the `curPc` of the entry cycle.
- R3: In user mode, a cycle with `instrDone`=1 and `extIrq`=1 has the same effect as R2: the load value is 0x0002, supervisor mode is set and `curPc` is saved.
- R4: When `instrDone`=0, `swTrap`, `extIrq` and `retReq` have no effect: `pcLoad` stays 0, and neither the mode nor the saved PC changes.
- R5: When `swTrap` and `extIrq` are both high at one boundary, exactly one entry happens, taken as the software trap. An `extIrq` that is still held high is taken at the first boundary after the return.
- R6: In supervisor mode, `swTrap` and `extIrq` are ignored: `pcLoad` stays 0 unless a return is requested, and the saved PC is not overwritten by `curPc`.
- R7: In supervisor mode, a boundary with `retReq`=1 drives `pcLoad`=1 with `pcLoadVal` equal to the saved user PC. From the next cycle, `superMode`=0.
- R8: In user mode, `retReq` is ignored: `pcLoad` stays 0 and the mode stays user.
- R9: `setUpcEn`=1 writes `setUpcVal` into the saved user PC, and it is visible on `upcRead` from the next cycle.
- R10: If an entry and `setUpcEn` fall in the same cycle, the entry wins and the saved PC becomes `curPc`.
- R11: If a return and `setUpcEn` fall in the same cycle, the return loads the old saved value and the saved PC then holds `setUpcVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrDone | input | 1 | Instruction boundary strobe |
| swTrap | input | 1 | Software request to enter supervisor mode |
| extIrq | input | 1 | Level-sensitive peripheral interrupt |
| retReq | input | 1 | Request to return to user mode |
| curPc | input | 16 | Program counter of the interrupted flow |
| setUpcEn | input | 1 | Write strobe for the saved user PC |
| setUpcVal | input | 16 | Value written into the saved user PC |
| upcRead | output | 16 | Current saved user PC |
| pcLoad | output | 1 | Load the program counter at the next edge |
| pcLoadVal | output | 16 | Value for the program counter |
| superMode | output | 1 | 1 while in supervisor mode |

## Verification
Three pairs of functions can meet in a single cycle:
- the software trap and the external interrupt;
- a saved-PC write and an entry;
- a saved-PC write and a return.

The bench drives each pair directly at one instruction boundary. It also lets a random phase raise all request lines together with independent probabilities. For each pair, a behavioural model settles which action wins: the trap over the interrupt, the entry over the write, and the old saved value for the return. The model also tracks whether a still-high interrupt is taken again after the return. It compares every output with the design on every clock.

// File: rtl/supv_trap_pkg.sv
package supv_trap_pkg;
  typedef struct packed {
    logic enter;   // take an entry this cycle
    logic leave;   // take a return this cycle
    logic wrUpc;   // software write to the saved user PC
  } trapStrobes_t;
endpackage

// File: rtl/supv_trap_ctl.sv
module supv_trap_ctl
  import supv_trap_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrDone,
  input  logic         swTrap,
  input  logic         extIrq,
  input  logic         retReq,
  input  logic         setUpcEn,
  output trapStrobes_t strobes,
  output logic         superMode
);
  typedef enum logic [1:0] {SRC_NONE, SRC_SW, SRC_IRQ} entrySrc_t;
  entrySrc_t entrySrc;

  // Software trap has priority; interrupt stays pending by level.
  always_comb begin
    entrySrc = SRC_NONE;
    if (instrDone && !superMode) begin
      if (swTrap)      entrySrc = SRC_SW;
      else if (extIrq) entrySrc = SRC_IRQ;
    end
  end

  always_comb begin
    strobes.enter = (entrySrc != SRC_NONE);
    strobes.leave = instrDone && superMode && retReq;
    strobes.wrUpc = setUpcEn && (entrySrc == SRC_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              superMode <= 1'b0;
    else if (strobes.enter) superMode <= 1'b1;
    else if (strobes.leave) superMode <= 1'b0;
  end

  assert_stay_super_R6: assert property (@(posedge clk) disable iff (!rstN)
    (superMode && !(instrDone && retReq)) |=> superMode);
  assert_user_ret_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!superMode && !swTrap && !extIrq) |=> !superMode);
  assert_boundary_R4: assert property (@(posedge clk) disable iff (!rstN)
    !instrDone |=> $stable(superMode));
endmodule

// File: rtl/supv_trap_dp.sv
module supv_trap_dp
  import supv_trap_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  trapStrobes_t    strobes,
  input  logic [PC_W-1:0] curPc,
  input  logic [PC_W-1:0] setUpcVal,
  output logic [PC_W-1:0] upc,
  output logic            pcLoad,
  output logic [PC_W-1:0] pcLoadVal
);
  always_comb begin
    pcLoad    = strobes.enter || strobes.leave;
    pcLoadVal = strobes.enter ? VEC_ADDR : upc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              upc <= '0;
    else if (strobes.enter) upc <= curPc;
    else if (strobes.wrUpc) upc <= setUpcVal;
  end

  assert_save_pc_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (upc == $past(curPc)));
  assert_set_upc_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrUpc |=> (upc == $past(setUpcVal)));
endmodule

// File: rtl/supv_trap_ctrl.sv
module supv_trap_ctrl
  import supv_trap_pkg::*;
#(
  parameter int unsigned PC_W = 16,
  parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(2)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrDone,
  input  logic            swTrap,
  input  logic            extIrq,
  input  logic            retReq,
  input  logic [PC_W-1:0] curPc,
  input  logic            setUpcEn,
  input  logic [PC_W-1:0] setUpcVal,
  output logic [PC_W-1:0] upcRead,
  output logic            pcLoad,
  output logic [PC_W-1:0] pcLoadVal,
  output logic            superMode
);
  trapStrobes_t strobes;

  supv_trap_ctl u_ctl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .swTrap(swTrap),
    .extIrq(extIrq), .retReq(retReq), .setUpcEn(setUpcEn),
    .strobes(strobes), .superMode(superMode)
  );

  supv_trap_dp #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPc(curPc),
    .setUpcVal(setUpcVal), .upc(upcRead), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal)
  );

  assert_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !superMode) |-> (pcLoadVal == VEC_ADDR));
  assert_ret_val_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && superMode) |-> (pcLoadVal == upcRead));
  assert_ret_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && superMode) |=> !superMode);
  assert_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !superMode) |=> (superMode && upcRead == $past(curPc)));
  assert_ret_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && superMode && setUpcEn) |=> (upcRead == $past(setUpcVal)));
endmodule

// File: tb/supv_trap_ctrl_bench.sv
module supv_trap_ctrl_bench;
  logic clk = 0, rstN = 0;
  logic instrDone = 0, swTrap = 0, extIrq = 0, retReq = 0, setUpcEn = 0;
  logic [15:0] curPc = 0, setUpcVal = 0;
  logic [15:0] upcRead, pcLoadVal;
  logic pcLoad, superMode;
  int total = 0, bad = 0;
  bit mMode = 0;
  int mUpc = 0;

  always #10 clk = ~clk;

  supv_trap_ctrl u_supv_trap_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .swTrap(swTrap),
    .extIrq(extIrq), .retReq(retReq), .curPc(curPc), .setUpcEn(setUpcEn),
    .setUpcVal(setUpcVal), .upcRead(upcRead), .pcLoad(pcLoad),
    .pcLoadVal(pcLoadVal), .superMode(superMode)
  );

  task automatic check(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle, compare against the model, then advance the model.
  task automatic step(string req, bit d, bit sw, bit irq, bit rt, bit se,
                      logic [15:0] sv, logic [15:0] pc);
    bit eLoad, enter, leave;
    int eVal;
    @(negedge clk);
    instrDone = d; swTrap = sw; extIrq = irq; retReq = rt;
    setUpcEn = se; setUpcVal = sv; curPc = pc;
    #2;
    enter = d && !mMode && (sw || irq);
    leave = d && mMode && rt;
    eLoad = enter || leave;
    eVal  = enter ? 2 : (leave ? mUpc : 0);
    check(req, pcLoad, eLoad, "pcLoad");
    if (eLoad) check(req, pcLoadVal, eVal, "pcLoadVal");
    check(req, superMode, mMode, "superMode");
    check(req, upcRead, mUpc, "upcRead");
    @(posedge clk);
    if (enter) begin mUpc = pc; mMode = 1; end
    else begin
      if (leave) mMode = 0;
      if (se) mUpc = sv;
    end
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", superMode, 0, "superMode"); check("R1", upcRead, 0, "upcRead");
    check("R1", pcLoad, 0, "pcLoad");
    @(negedge clk); rstN = 1;
    step("R4", 0, 1, 1, 1, 0, 0, 16'h1111);
    step("R2", 1, 1, 0, 0, 0, 0, 16'h1234);
    step("R2", 0, 0, 0, 0, 0, 0, 16'h0);
    step("R6", 1, 1, 0, 0, 0, 0, 16'h2222);
    step("R6", 1, 0, 1, 0, 0, 0, 16'h3333);
    step("R9", 0, 0, 0, 0, 1, 16'hBEEF, 0);
    step("R7", 1, 0, 0, 1, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 1, 0, 0, 0, 16'h0040);
    step("R5", 1, 0, 1, 1, 0, 0, 0);
    step("R5", 1, 0, 1, 0, 0, 0, 16'h0050);
    step("R7", 1, 0, 0, 1, 0, 0, 0);
    step("R10", 1, 1, 0, 0, 1, 16'h5555, 16'h0100);
    step("R11", 1, 0, 0, 1, 1, 16'h7777, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 1, 0, 0, 0, 16'h0A0A);
    step("R3", 1, 0, 1, 0, 0, 0, 16'h0B0B);
    step("R3", 0, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      step("R6/R7/R9 random", ($urandom % 4) != 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0,
           16'($urandom), 16'($urandom));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule